// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the effective memory address and the base-register update for single-register load and store instructions of a 32-bit RISC core. The block covers word, byte and halfword transfers. Each cycle it can accept one instruction word, together with the current base register value, the value of the register named as an offset, and the carry flag. One cycle later it returns the access address, whether the base register must be written back and with what value, the access size, and a flag that marks an unprivileged (translated) access.

The offset can come from a 12-bit immediate or from a register shifted by a constant amount. For halfword transfers it can also come from an 8-bit immediate split across two nibbles of the instruction, or from an unshifted register. The offset is added or subtracted according to a direction bit. Pre-indexed addressing uses the adjusted address and writes it back only on request. Post-indexed addressing accesses at the unmodified base and always updates it.

Register file reads, memory access and data alignment belong to neighbouring blocks. The outputs are captured in a register stage qualified by a valid strobe.

Top module: `lsagu`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high and low otherwise. While `in_valid` is low, all result outputs hold their previous values.
- R2: When instr[27:26]=01 and instr[25]=0, the offset magnitude is instr[11:0], zero-extended.
- R3: When instr[27:26]=01 and instr[25]=1, the offset magnitude is `ofs_val` shifted by the amount in instr[11:7], using the shift type in instr[6:5]. The types are 00 left logical, 01 right logical, 10 right arithmetic and 11 rotate right. An amount of 0 has a special meaning for the last three types. Right logical by 0 gives 0. Right arithmetic by 0 fills the result with the sign bit. Rotate by 0 gives {carry_in, ofs_val[31:1]}.
- R4: When instr[27:26]≠01, the transfer is a halfword. In that case instr[22]=1 gives the offset {instr[11:8], instr[3:0]}, and instr[22]=0 gives `ofs_val` unshifted.
- R5: With instr[23]=1 the offset is added to the base. With instr[23]=0 it is subtracted.
- R6: With instr[24]=1 (pre-indexed), `mem_addr` is base±offset, `wb_en` equals instr[21], and `wb_val` equals `mem_addr`.
- R7: With instr[24]=0 (post-indexed), `mem_addr` is the unmodified base, `wb_en` is 1, and `wb_val` is base±offset.
- R8: `wb_idx` carries the base register index instr[19:16].
- R9: `acc_size` is 00 for byte (word/byte class with instr[22]=1), 01 for halfword, and 10 for word.
- R10: `user_acc` is 1 only for a post-indexed word/byte transfer with instr[21]=1.
- R11: After reset, `out_valid` is 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands valid |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Base register value |
| ofs_val | input | 32 | Offset register value |
| carry_in | input | 1 | Carry flag, used by rotate-by-zero |
| out_valid | output | 1 | Result valid |
| mem_addr | output | 32 | Access address |
| wb_en | output | 1 | Base register writeback enable |
| wb_idx | output | 4 | Base register index for writeback |
| wb_val | output | 32 | Base register writeback value |
| acc_size | output | 2 | Access size: 00 byte, 01 halfword, 10 word |
| user_acc | output | 1 | Unprivileged access marker |

## Verification
The bench aims directed instructions at the shift-by-zero encodings. A design that took the amount literally would return the offset unchanged for right logical, right arithmetic and rotate, instead of returning zero, the sign fill and the rotate-through-carry result. Further cases cover the split halfword immediate, which a wrong design would assemble with its nibbles swapped or as a 12-bit field. They also cover subtracting offsets and pre-indexed transfers without writeback. Post-indexed transfers with bit 21 set must be flagged as unprivileged and must still write back. A design that gated post-index writeback on bit 21, or placed the adjusted address on the bus, would show a wrong `wb_en` or `mem_addr`.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic [31:0] addr;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_val;
    acc_size_e   size;
    logic        user;
  } agu_res_t;

endpackage

// File: rtl/lsagu_shift.sv
module lsagu_shift #(
  parameter int DW = 32,
  localparam int AW = $clog2(DW)
) (
  input  logic [DW-1:0]             val,
  input  logic [AW-1:0]             amt,
  input  lsagu_pkg::shift_kind_e    kind,
  input  logic                      carry,
  output logic [DW-1:0]             res
);
  import lsagu_pkg::*;

  logic [2*DW-1:0] rot_wide;
  logic            amt_zero;

  assign amt_zero = (amt == '0);
  assign rot_wide = {val, val} >> amt;

  always_comb begin
    unique case (kind)
      SH_LSL: res = val << amt;
      SH_LSR: res = amt_zero ? '0 : (val >> amt);
      SH_ASR: res = amt_zero ? {DW{val[DW-1]}} : DW'($signed(val) >>> amt);
      default: res = amt_zero ? {carry, val[DW-1:1]} : rot_wide[DW-1:0];
    endcase
  end

endmodule

// File: rtl/lsagu_decode.sv
module lsagu_decode #(
  parameter int DW = 32
) (
  input  logic [31:0]            instr,
  input  logic [DW-1:0]          ofs_val,
  input  logic                   carry_in,
  output logic [DW-1:0]          mag,
  output logic                   up,
  output logic                   pre,
  output logic                   wb_req,
  output logic [3:0]             base_idx,
  output lsagu_pkg::acc_size_e   size,
  output logic                   user
);
  import lsagu_pkg::*;

  localparam int AW = $clog2(DW);

  logic          is_half;
  logic          reg_form;
  logic [DW-1:0] shifted;
  logic [DW-1:0] imm12;
  logic [DW-1:0] imm8;

  assign is_half  = (instr[27:26] != 2'b01);
  assign reg_form = instr[25];
  assign up       = instr[23];
  assign pre      = instr[24];
  assign wb_req   = instr[21];
  assign base_idx = instr[19:16];
  assign imm12    = DW'(instr[11:0]);
  assign imm8     = DW'({instr[11:8], instr[3:0]});

  lsagu_shift #(.DW(DW)) u_shift (
    .val   (ofs_val),
    .amt   (instr[7+AW-1:7]),
    .kind  (shift_kind_e'(instr[6:5])),
    .carry (carry_in),
    .res   (shifted)
  );

  always_comb begin
    if (is_half) begin
      mag  = instr[22] ? imm8 : ofs_val;
      size = SZ_HALF;
      user = 1'b0;
    end else begin
      mag  = reg_form ? shifted : imm12;
      size = instr[22] ? SZ_BYTE : SZ_WORD;
      user = ~instr[24] & instr[21];
    end
  end

endmodule

// File: rtl/lsagu_addr.sv
module lsagu_addr #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] mag,
  input  logic          up,
  input  logic          pre,
  input  logic          wb_req,
  output logic [DW-1:0] addr,
  output logic          wb_en,
  output logic [DW-1:0] wb_val
);

  logic [DW-1:0] moved;

  assign moved = up ? (base + mag) : (base - mag);

  always_comb begin
    wb_val = moved;
    if (pre) begin
      addr  = moved;
      wb_en = wb_req;
    end else begin
      addr  = base;
      wb_en = 1'b1;
    end
  end

endmodule

// File: rtl/lsagu.sv
module lsagu #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] ofs_val,
  input  logic          carry_in,
  output logic          out_valid,
  output logic [DW-1:0] mem_addr,
  output logic          wb_en,
  output logic [3:0]    wb_idx,
  output logic [DW-1:0] wb_val,
  output logic [1:0]    acc_size,
  output logic          user_acc
);
  import lsagu_pkg::*;

  logic [1:0]    rst_sync;
  logic          rst_int_n;

  logic [DW-1:0] mag;
  logic          up, pre, wb_req, user_d, wb_en_d;
  logic [3:0]    idx_d;
  acc_size_e     size_d;
  logic [DW-1:0] addr_d, wbv_d;

  logic          vld_q;
  logic [DW-1:0] addr_q, wbv_q;
  logic          wben_q, user_q;
  logic [3:0]    idx_q;
  logic [1:0]    size_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lsagu_decode #(.DW(DW)) u_dec (
    .instr    (instr),
    .ofs_val  (ofs_val),
    .carry_in (carry_in),
    .mag      (mag),
    .up       (up),
    .pre      (pre),
    .wb_req   (wb_req),
    .base_idx (idx_d),
    .size     (size_d),
    .user     (user_d)
  );

  lsagu_addr #(.DW(DW)) u_addr (
    .base   (base_val),
    .mag    (mag),
    .up     (up),
    .pre    (pre),
    .wb_req (wb_req),
    .addr   (addr_d),
    .wb_en  (wb_en_d),
    .wb_val (wbv_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= 1'b0;
    else            vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
      wbv_q  <= '0;
      wben_q <= 1'b0;
      idx_q  <= '0;
      size_q <= '0;
      user_q <= 1'b0;
    end else if (in_valid) begin
      addr_q <= addr_d;
      wbv_q  <= wbv_d;
      wben_q <= wb_en_d;
      idx_q  <= idx_d;
      size_q <= size_d;
      user_q <= user_d;
    end
  end

  assign out_valid = vld_q;
  assign mem_addr  = addr_q;
  assign wb_en     = wben_q;
  assign wb_idx    = idx_q;
  assign wb_val    = wbv_q;
  assign acc_size  = size_q;
  assign user_acc  = user_q;

endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [31:0]   instr,
  input logic [DW-1:0] base_val,
  input logic [DW-1:0] ofs_val,
  input logic          carry_in,
  input logic          out_valid,
  input logic [DW-1:0] mem_addr,
  input logic          wb_en,
  input logic [3:0]    wb_idx,
  input logic [DW-1:0] wb_val,
  input logic [1:0]    acc_size,
  input logic          user_acc
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(mem_addr) && $stable(wb_val));

  // R7
  post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !instr[24] |=> mem_addr == $past(base_val) && wb_en);

  // R6
  pre_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr[24] && !instr[21] |=> !wb_en && wb_val == mem_addr);

  // R2
  imm_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr[27:25] == 3'b010 && instr[24] && instr[23]
    |=> mem_addr == $past(base_val) + DW'($past(instr[11:0])));

  // R8
  idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> wb_idx == $past(instr[19:16]));

  // R10
  user_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && user_acc |-> acc_size != 2'b01 && wb_en);

endmodule

bind lsagu lsagu_chk #(.DW(DW)) u_chk (.*);

// File: tb/lsagu_test.sv
`timescale 1ns/1ps
module lsagu_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr, base_val, ofs_val;
  logic        carry_in;
  logic        out_valid, wb_en, user_acc;
  logic [31:0] mem_addr, wb_val;
  logic [3:0]  wb_idx;
  logic [1:0]  acc_size;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsagu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .base_val(base_val), .ofs_val(ofs_val), .carry_in(carry_in),
    .out_valid(out_valid), .mem_addr(mem_addr), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_val(wb_val), .acc_size(acc_size),
    .user_acc(user_acc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_mag(input logic [31:0] ins, input logic [31:0] ofs,
                                          input logic c, output string tag);
    logic [4:0] a;
    a = ins[11:7];
    if (ins[27:26] != 2'b01) begin
      tag = "R4";
      return ins[22] ? {24'd0, ins[11:8], ins[3:0]} : ofs;
    end
    if (!ins[25]) begin
      tag = "R2";
      return {20'd0, ins[11:0]};
    end
    tag = "R3";
    case (ins[6:5])
      2'b00: return ofs << a;
      2'b01: return (a == 0) ? 32'd0 : ofs >> a;
      2'b10: return (a == 0) ? (ofs[31] ? 32'hFFFF_FFFF : 32'd0) : 32'($signed(ofs) >>> a);
      default: return (a == 0) ? {c, ofs[31:1]} : ((ofs >> a) | (ofs << (6'd32 - {1'b0, a})));
    endcase
  endfunction

  task automatic run_one(input logic [31:0] ins, input logic [31:0] b,
                         input logic [31:0] o, input logic c);
    string       mt, pt;
    logic [31:0] mag, tgt, ea;
    logic        half;
    @(negedge clk);
    instr = ins; base_val = b; ofs_val = o; carry_in = c; in_valid = 1'b1;
    mag  = ref_mag(ins, o, c, mt);
    tgt  = ins[23] ? b + mag : b - mag;
    half = (ins[27:26] != 2'b01);
    ea   = ins[24] ? tgt : b;
    pt   = ins[24] ? "R6" : "R7";
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 out_valid", {31'd0, out_valid}, 32'd1);
    chk({pt, " mem_addr"}, mem_addr, ea);
    chk({pt, " wb_en"}, {31'd0, wb_en}, {31'd0, ins[24] ? ins[21] : 1'b1});
    chk({mt, " R5 wb_val"}, wb_val, tgt);
    chk("R8 wb_idx", {28'd0, wb_idx}, {28'd0, ins[19:16]});
    chk("R9 acc_size", {30'd0, acc_size},
        {30'd0, half ? 2'b01 : (ins[22] ? 2'b00 : 2'b10)});
    chk("R10 user_acc", {31'd0, user_acc},
        {31'd0, !half && !ins[24] && ins[21]});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] hold_a;
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; base_val = '0; ofs_val = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    // R11
    chk("R11 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R11 mem_addr", mem_addr, 32'd0);
    chk("R11 wb_val", wb_val, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_one(32'hE5B34123, 32'h0000_1000, 32'h0, 1'b0);  // R2 pre up writeback word
    run_one(32'hE5434FFF, 32'h0000_1000, 32'h0, 1'b0);  // R5 down, R6 no writeback, byte
    run_one(32'hE4B12004, 32'h0000_2000, 32'h0, 1'b0);  // R7 R10 post unprivileged
    run_one(32'hE7825026, 32'h0000_3000, 32'h8000_0000, 1'b0); // R3 LSR by 0
    run_one(32'hE7825046, 32'h0000_3000, 32'h8000_0000, 1'b0); // R3 ASR by 0
    run_one(32'hE7825066, 32'h0000_3000, 32'h0000_0002, 1'b1); // R3 rotate by 0 with carry
    run_one(32'hE6025206, 32'h0000_4000, 32'h0000_0003, 1'b0); // R3 LSL 4, post down
    run_one(32'hE1F12ABB, 32'h0000_5000, 32'h0, 1'b0);  // R4 split immediate
    run_one(32'hE00120B7, 32'h0000_5000, 32'h0000_0010, 1'b0); // R4 register, post down

    // R1 idle: no valid, outputs hold
    hold_a = mem_addr;
    @(negedge clk);
    chk("R1 idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 hold mem_addr", mem_addr, hold_a);

    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[0]) r[27:26] = 2'b01;
      else begin
        r[27:25] = 3'b000; r[7] = 1'b1; r[4] = 1'b1;
        if (r[6:5] == 2'b00) r[5] = 1'b1;
      end
      run_one(r, $urandom, $urandom, 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule